// File: doc/BRIEF.md
# BT.656 Sync and Active-Video Timing Generator

This block sits after a video timing source that supplies a byte-clock position within the line and a line number within the frame. From these counters it builds an 8-bit multiplexed component stream in which the four-byte timing references are inserted. The end-of-active reference opens horizontal blanking and the start-of-active reference closes it. Pixel bytes from upstream pass through inside the active region and are clipped so that they never look like a timing reference. Blanking bytes fill the rest of the line.

Beside the stream it drives a discrete horizontal sync pulse. An 8-bit code shifts the pulse in steps of four clocks around a nominal position. It also drives an active-video strobe whose pixel window is set by crop start and stop values. These values take effect only on the cycle their write strobe is raised. The field and vertical-blanking bits in the references follow a selectable mode, either the standard 525-line assignment or one of two schemes for nonstandard line counts. All settings arrive as input ports.

Top module: `bt656_sync_gen`

## Requirements
- R1: Every output is registered, one clock after the counters. For `h_cnt` from H_ACTIVE to H_ACTIVE+3 the stream carries FF, 00, 00, XY with H=1. For `h_cnt` from H_TOTAL-4 to H_TOTAL-1 it carries the same sequence with H=0.
- R2: The XY byte is, from bit 7 down: 1, F, V, H, V^H, F^H, F^V, F^V^H.
- R3: F and V are updated only on the cycle `h_cnt` equals H_ACTIVE, the first byte of the end-of-active reference. They take the values of the next line, which is `v_cnt`+1, wrapping to 0 at `line_total`. The following start-of-active reference and active region use the same values, even if `v_cnt` changes in between.
- R4: With `fv_mode` 00 or 11 (standard), and 0-based line n, F=1 for n<3 or n>=265. V=1 for n<19 or 263<=n<282.
- R5: With `fv_mode` 01 (nonstandard even), F is forced to 1. Fields start at line 0 and at line `line_total`/2 (rounded down). V=1 for the first 19 lines of each field and 0 after.
- R6: With `fv_mode` 10 (nonstandard odd), F inverts at each update whose next line starts a field, and holds otherwise. V follows R5.
- R7: Inside the active region (`h_cnt` < H_ACTIVE while V=0) the output is `pix_in`, with 00 replaced by 01 and FF replaced by FE.
- R8: Outside the references and the active region, and in every position while V=1, the output is blanking. Bytes follow the order Cb, Y, Cr, Y, so even `h_cnt` gives 80 and odd `h_cnt` gives 10.
- R9: `hsync` is high for HS_WIDTH clocks. The pulse starts at position (HS_BASE + (128 - `hs_code`)*4) mod H_TOTAL. So code 80 gives HS_BASE, FF gives HS_BASE-508 and 00 gives HS_BASE+512.
- R10: `avid` is high when the pixel index `h_cnt`/2 lies in [start, stop'). Here stop' is the stop value minus one when stop-start is odd, which keeps the window even. The window is empty when stop <= start.
- R11: The crop start and stop are taken from `crop_start` and `crop_stop` only on cycles where `crop_start_wr` or `crop_stop_wr` is high. Changes at other times have no effect.
- R12: With `avid_vblk_off` high, `avid` stays low while V=1. With it low, the window of R10 applies on every line.
- R13: During reset `dout` is 10, `hsync` and `avid` are 0, F and V are 1, and the crop window is [0, H_ACTIVE/2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_cnt | input | HW | Byte position within the line, 0 to H_TOTAL-1 |
| v_cnt | input | VW | Line number within the frame, 0-based |
| line_total | input | VW | Lines per frame, used for wrap and field split |
| fv_mode | input | 2 | Field/vertical bit scheme (R4 to R6) |
| pix_in | input | 8 | Multiplexed pixel byte from upstream |
| hs_code | input | 8 | Horizontal sync offset code |
| crop_start | input | HW-1 | First active pixel |
| crop_start_wr | input | 1 | Takes `crop_start` |
| crop_stop | input | HW-1 | Pixel after the last active pixel |
| crop_stop_wr | input | 1 | Takes `crop_stop` |
| avid_vblk_off | input | 1 | Holds `avid` low during vertical blanking |
| dout | output | 8 | Output byte stream |
| hsync | output | 1 | Horizontal sync pulse |
| avid | output | 1 | Active-video strobe |

## Verification
The embedded assertions watch every cycle for several properties. The first three are that F and V move only after the end-of-active position, that each reference begins with FF, and that no byte emitted in the active region is 00 or FF. The others are that the crop start holds without its strobe, and that `avid` stays low in vertical blanking when masked. The exact F/V sequences of the three modes, including the F toggle at field starts, can only be shown by the bench scenarios. The same holds for the protection bits, the pulse position for different sync codes, and the crop window edges with an odd width.

// File: rtl/bt656_sync_gen.sv
module bt656_sync_gen #(
  parameter int H_TOTAL       = 1716,
  parameter int H_ACTIVE      = 1440,
  parameter int HS_BASE       = 1472,
  parameter int HS_WIDTH      = 128,
  parameter int VW            = 11,
  parameter int VBL_LINES     = 19,
  parameter int STD_F_END     = 3,
  parameter int STD_F_START   = 265,
  parameter int STD_V1_END    = 19,
  parameter int STD_V2_START  = 263,
  parameter int STD_V2_END    = 282,
  localparam int HW           = $clog2(H_TOTAL),
  localparam int PW           = HW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] h_cnt,
  input  logic [VW-1:0] v_cnt,
  input  logic [VW-1:0] line_total,
  input  logic [1:0]    fv_mode,
  input  logic [7:0]    pix_in,
  input  logic [7:0]    hs_code,
  input  logic [PW-1:0] crop_start,
  input  logic          crop_start_wr,
  input  logic [PW-1:0] crop_stop,
  input  logic          crop_stop_wr,
  input  logic          avid_vblk_off,
  output logic [7:0]    dout,
  output logic          hsync,
  output logic          avid
);
  localparam int HPW = HW + 2;
  localparam int HS_RAW = HS_BASE + H_TOTAL + 512;
  localparam logic [HW-1:0] HA  = HW'(H_ACTIVE);
  localparam logic [HW-1:0] HA3 = HW'(H_ACTIVE + 3);
  localparam logic [HW-1:0] HT4 = HW'(H_TOTAL - 4);
  localparam logic [1:0] EAV_PH = 2'(H_ACTIVE);
  localparam logic [1:0] SAV_PH = 2'(H_TOTAL - 4);
  localparam logic [HPW-1:0] HT_W = HPW'(H_TOTAL);

  logic f_q, v_q, act_q;
  logic [PW-1:0] start_q, stop_q;

  // next-line field and vertical bits
  wire [VW-1:0] v_inc  = v_cnt + 1'b1;
  wire [VW-1:0] v_nx   = (v_inc >= line_total) ? '0 : v_inc;
  wire [VW-1:0] half   = line_total >> 1;
  wire [VW-1:0] f_off  = (v_nx >= half) ? v_nx - half : v_nx;
  wire          ns_v   = f_off < VW'(VBL_LINES);
  wire          fstart = (v_nx == '0) || (v_nx == half);
  wire          std_f  = (v_nx < VW'(STD_F_END)) || (v_nx >= VW'(STD_F_START));
  wire          std_v  = (v_nx < VW'(STD_V1_END)) ||
                         ((v_nx >= VW'(STD_V2_START)) && (v_nx < VW'(STD_V2_END)));
  wire          eav_go = h_cnt == HA;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_q <= 1'b1;
      v_q <= 1'b1;
    end else if (eav_go) begin
      case (fv_mode)
        2'b01: begin f_q <= 1'b1;             v_q <= ns_v;  end
        2'b10: begin f_q <= f_q ^ fstart;     v_q <= ns_v;  end
        default: begin f_q <= std_f;          v_q <= std_v; end
      endcase
    end
  end

  // timing reference insertion
  wire       in_eav = (h_cnt >= HA) && (h_cnt <= HA3);
  wire       in_sav = h_cnt >= HT4;
  wire [1:0] k      = h_cnt[1:0] - (in_eav ? EAV_PH : SAV_PH);
  wire       hb     = in_eav;
  wire [7:0] xy     = {1'b1, f_q, v_q, hb, v_q ^ hb, f_q ^ hb, f_q ^ v_q, f_q ^ v_q ^ hb};
  wire [7:0] code_b = (k == 2'd0) ? 8'hFF : (k == 2'd3) ? xy : 8'h00;
  wire       act    = (h_cnt < HA) && !v_q;
  wire [7:0] clip   = (pix_in == 8'h00) ? 8'h01 : (pix_in == 8'hFF) ? 8'hFE : pix_in;
  wire [7:0] blank  = h_cnt[0] ? 8'h10 : 8'h80;
  wire [7:0] d_nx   = (in_eav || in_sav) ? code_b : act ? clip : blank;

  // horizontal sync position
  wire [HPW-1:0] hs_r0 = HPW'(HS_RAW) - HPW'({hs_code, 2'b00});
  wire [HPW-1:0] hs_r1 = (hs_r0 >= HT_W) ? hs_r0 - HT_W : hs_r0;
  wire [HPW-1:0] hs_r2 = (hs_r1 >= HT_W) ? hs_r1 - HT_W : hs_r1;
  wire [HPW-1:0] h_w   = HPW'(h_cnt);
  wire [HPW-1:0] hs_d  = (h_w >= hs_r2) ? h_w - hs_r2 : h_w + HT_W - hs_r2;
  wire           hs_nx = hs_d < HPW'(HS_WIDTH);

  // active-video window
  wire [PW-1:0] px      = h_cnt[HW-1:1];
  wire [PW-1:0] stop_e  = stop_q - PW'(stop_q[0] ^ start_q[0]);
  wire          win     = (stop_q > start_q) && (px >= start_q) && (px < stop_e);
  wire          avid_nx = win && !(avid_vblk_off && v_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      stop_q  <= PW'(H_ACTIVE / 2);
    end else begin
      if (crop_start_wr) start_q <= crop_start;
      if (crop_stop_wr)  stop_q  <= crop_stop;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout  <= 8'h10;
      hsync <= 1'b0;
      avid  <= 1'b0;
      act_q <= 1'b0;
    end else begin
      dout  <= d_nx;
      hsync <= hs_nx;
      avid  <= avid_nx;
      act_q <= act && !(in_eav || in_sav);
    end
  end

  p_fv_eav_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({f_q, v_q}) |-> $past(h_cnt) == HA);
  p_eav_lead_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt == HA) |=> dout == 8'hFF);
  p_sav_lead_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt == HT4) |=> dout == 8'hFF);
  p_no_code_in_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (dout != 8'h00) && (dout != 8'hFF));
  p_crop_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !crop_start_wr |=> $stable(start_q));
  p_avid_vblank_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (avid_vblk_off && v_q) |=> !avid);
endmodule

// File: tb/bt656_sync_gen_test.sv
module bt656_sync_gen_test;
  localparam int HT = 1716, HA = 1440, HSB = 1472, HSW = 128;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [10:0] h_cnt = '0;
  logic [10:0] v_cnt = '0, line_total = 11'd525;
  logic [1:0]  fv_mode = 2'b00;
  logic [7:0]  pix_in = '0, hs_code = 8'h80;
  logic [9:0]  crop_start = '0, crop_stop = '0;
  logic        crop_start_wr = 1'b0, crop_stop_wr = 1'b0, avid_vblk_off = 1'b0;
  logic [7:0]  dout;
  logic        hsync, avid;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bt656_sync_gen uut (
    .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt), .line_total(line_total),
    .fv_mode(fv_mode), .pix_in(pix_in), .hs_code(hs_code),
    .crop_start(crop_start), .crop_start_wr(crop_start_wr),
    .crop_stop(crop_stop), .crop_stop_wr(crop_stop_wr),
    .avid_vblk_off(avid_vblk_off), .dout(dout), .hsync(hsync), .avid(avid));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] xy(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic cyc(input int h, input int v, input logic [7:0] px);
    h_cnt = 11'(h); v_cnt = 11'(v); pix_in = px;
    @(negedge clk);
  endtask

  task automatic ref_code(input int base, input int v, input string req, output logic [7:0] x);
    cyc(base, v, 8'h00);     chk({req, " byte0"}, dout, 8'hFF);
    cyc(base + 1, v, 8'h00); chk({req, " byte1"}, dout, 8'h00);
    cyc(base + 2, v, 8'h00); chk({req, " byte2"}, dout, 8'h00);
    cyc(base + 3, v, 8'h00); x = dout;
  endtask

  task automatic eav_xy(input int v, input logic f, input logic vb, input string req);
    logic [7:0] x;
    ref_code(HA, v, "R1 eav", x);
    chk({req, " eav xy"}, x, xy(f, vb, 1'b1));
  endtask

  task automatic t_reset;
    chk("R13 reset dout", dout, 8'h10);
    chk("R13 reset hsync", hsync, 0);
    chk("R13 reset avid", avid, 0);
  endtask

  task automatic t_ref_codes;
    logic [7:0] x;
    fv_mode = 2'b00; line_total = 11'd525;
    eav_xy(10, 1'b0, 1'b1, "R1 R2");
    ref_code(HT - 4, 10, "R1 sav", x);
    chk("R2 sav xy", x, xy(1'b0, 1'b1, 1'b0));
  endtask

  task automatic t_std_fields;
    fv_mode = 2'b00;
    eav_xy(2, 1'b0, 1'b1, "R4 line3");
    eav_xy(18, 1'b0, 1'b0, "R4 line19");
    eav_xy(262, 1'b0, 1'b1, "R4 line263");
    eav_xy(264, 1'b1, 1'b1, "R4 line265");
    eav_xy(281, 1'b1, 1'b0, "R4 line282");
    fv_mode = 2'b11;
    eav_xy(524, 1'b1, 1'b1, "R4 wrap mode11");
  endtask

  task automatic t_fv_hold;
    logic [7:0] x;
    fv_mode = 2'b00;
    eav_xy(18, 1'b0, 1'b0, "R3 set");
    ref_code(HT - 4, 200, "R3 sav", x);
    chk("R3 sav keeps eav bits", x, xy(1'b0, 1'b0, 1'b0));
    cyc(6, 0, 8'h5A);
    chk("R3 active still open", dout, 8'h5A);
  endtask

  task automatic t_even;
    fv_mode = 2'b01; line_total = 11'd501;
    eav_xy(500, 1'b1, 1'b1, "R5 field1 start");
    eav_xy(18, 1'b1, 1'b0, "R5 field1 open");
    eav_xy(249, 1'b1, 1'b1, "R5 field2 start");
    eav_xy(268, 1'b1, 1'b0, "R5 field2 open");
  endtask

  task automatic t_odd;
    fv_mode = 2'b10; line_total = 11'd525;
    eav_xy(261, 1'b0, 1'b1, "R6 toggle");
    eav_xy(100, 1'b0, 1'b0, "R6 hold");
    eav_xy(524, 1'b1, 1'b1, "R6 toggle back");
  endtask

  task automatic t_active;
    fv_mode = 2'b00;
    eav_xy(100, 1'b0, 1'b0, "R7 prep");
    cyc(0, 101, 8'h00);    chk("R7 clip low", dout, 8'h01);
    cyc(1, 101, 8'hFF);    chk("R7 clip high", dout, 8'hFE);
    cyc(2, 101, 8'h5A);    chk("R7 pass", dout, 8'h5A);
    cyc(1439, 101, 8'h33); chk("R7 last active", dout, 8'h33);
    cyc(1500, 101, 8'h5A); chk("R8 hblank even", dout, 8'h80);
    cyc(1501, 101, 8'h5A); chk("R8 hblank odd", dout, 8'h10);
    eav_xy(0, 1'b1, 1'b1, "R8 prep");
    cyc(4, 1, 8'h5A);      chk("R8 vblank even", dout, 8'h80);
    cyc(5, 1, 8'h5A);      chk("R8 vblank odd", dout, 8'h10);
  endtask

  task automatic t_hsync(input logic [7:0] code);
    int pos;
    hs_code = code;
    pos = (HSB + (128 - int'(code)) * 4 + HT) % HT;
    cyc((pos + HT - 1) % HT, 50, 8'h00); chk("R9 before", hsync, 0);
    cyc(pos, 50, 8'h00);                 chk("R9 start", hsync, 1);
    cyc((pos + HSW - 1) % HT, 50, 8'h00); chk("R9 last", hsync, 1);
    cyc((pos + HSW) % HT, 50, 8'h00);    chk("R9 end", hsync, 0);
  endtask

  task automatic set_crop(input int s, input int e);
    crop_start = 10'(s); crop_stop = 10'(e);
    crop_start_wr = 1'b1; crop_stop_wr = 1'b1;
    @(negedge clk);
    crop_start_wr = 1'b0; crop_stop_wr = 1'b0;
  endtask

  task automatic t_avid;
    fv_mode = 2'b00; avid_vblk_off = 1'b0;
    eav_xy(100, 1'b0, 1'b0, "R10 prep");
    set_crop(10, 100);
    cyc(19, 101, 8'h20);  chk("R10 before start", avid, 0);
    cyc(20, 101, 8'h20);  chk("R10 start", avid, 1);
    cyc(199, 101, 8'h20); chk("R10 last", avid, 1);
    cyc(200, 101, 8'h20); chk("R10 stop", avid, 0);
    set_crop(10, 101);
    cyc(200, 101, 8'h20); chk("R10 odd width trimmed", avid, 0);
    cyc(198, 101, 8'h20); chk("R10 odd width inside", avid, 1);
    crop_start = 10'd50; crop_stop = 10'd20;
    cyc(20, 101, 8'h20);  chk("R11 start without strobe", avid, 1);
    cyc(150, 101, 8'h20); chk("R11 stop without strobe", avid, 1);
    eav_xy(0, 1'b1, 1'b1, "R12 prep");
    avid_vblk_off = 1'b1;
    cyc(40, 1, 8'h20);    chk("R12 masked", avid, 0);
    avid_vblk_off = 1'b0;
    cyc(40, 1, 8'h20);    chk("R12 unmasked", avid, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_ref_codes;
    t_std_fields;
    t_fv_hold;
    t_even;
    t_odd;
    t_active;
    t_hsync(8'h80);
    t_hsync(8'hFF);
    t_hsync(8'h00);
    t_avid;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule